// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block sits between a bus master and a register source whose reads cannot be trusted on every access. When the master hands it an address, the block reads that register repeatedly, one sample per clock, and keeps a table of the distinct values it has seen together with how many times each one appeared. It then returns the value that appeared most often.

A read is a fixed run of up to 100 samples. The run ends before the 100th sample as soon as one value has been seen more than 50 times, because no other value can then overtake it. When two values end with the same count, the one that reached that count first wins. The master issues a request with a valid/ready handshake and receives a one-cycle done pulse with the filtered word. The target register is read through a plain sample port: the block drives an address and an enable, and the target drives the data word in the same cycle.

Top module: `mvf_read_filter`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `smp_en` is 0, `rsp_done` is 0 and `rsp_data` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the read finishes, and a `req_valid` raised while a read is running is ignored: it neither restarts the read nor changes the sampled address.
- R3: From the edge after acceptance, `smp_en` is 1 for exactly as many cycles as samples are taken, and `smp_addr` equals the accepted address throughout. `smp_data` is captured on every edge where `smp_en` is 1.
- R4: When no value is seen more than 50 times, exactly 100 samples are taken.
- R5: The returned value is the value with the highest occurrence count among the samples taken.
- R6: When several values share the highest count, the value that reached that count first (in sample order) is returned.
- R7: The read stops on the sample that brings a value's count to 51, and that value is returned.
- R8: `rsp_done` is 1 for exactly one cycle, in the cycle right after the edge that took the last sample. `rsp_data` carries the result in that cycle and keeps it until the next `rsp_done`.
- R9: The tally from an earlier read has no effect on a later read: counts start from zero for every accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Master requests a filtered read |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | ADDR_W | Address of the register to read |
| smp_en | output | 1 | A sample is taken at the next edge |
| smp_addr | output | ADDR_W | Address presented to the target register |
| smp_data | input | DATA_W | Word returned by the target register |
| rsp_done | output | 1 | One-cycle pulse: filtered result is ready |
| rsp_data | output | DATA_W | Filtered (most frequent) value |

## Verification
The bound checker watches, on every cycle, the handshake and protocol shape: done lasting a single cycle and only while ready, the result word holding still outside done, the sample address holding steady through a run, a run never exceeding 100 samples, and sampling beginning right after an accepted request. Which value wins, when a tie goes to the earlier value, the exact sample on which a majority ends the run, and that a second read is not polluted by the first can only be shown by the bench's scenarios, which compare the design each cycle with a reference tally built from queues.

// File: rtl/mvf_pkg.sv
// Shared types for the majority-vote read filter.
package mvf_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SAMPLE = 1'b1
    } mvf_state_t;
endpackage

// File: rtl/mvf_tally_table.sv
// Table of distinct sampled values and their occurrence counts.
// Assumes: at most one valid entry can match a sample (entries are distinct),
// DEPTH >= number of samples per read so an insert never finds the table full.
// Produces the count the sample's entry holds after this update.
module mvf_tally_table #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 100,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] smp,
    output logic [CNT_W-1:0]  new_cnt
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]  hit;
    logic [CNT_W-1:0]  cnt_q [DEPTH];
    logic [FILL_W-1:0] fill_q;
    logic              any_hit;
    logic [CNT_W-1:0]  hit_cnt;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_entry
            logic              vld_q;
            logic [DATA_W-1:0] val_q;

            // Compare this entry with the incoming sample.
            assign hit[gi] = vld_q && (val_q == smp);

            // Hold one distinct value and its count; insert at the fill point.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q      <= 1'b0;
                    val_q      <= '0;
                    cnt_q[gi]  <= '0;
                end else if (clr) begin
                    vld_q      <= 1'b0;
                    cnt_q[gi]  <= '0;
                end else if (upd) begin
                    if (hit[gi]) begin
                        cnt_q[gi] <= cnt_q[gi] + 1'b1;
                    end else if (!any_hit && (fill_q == FILL_W'(gi))) begin
                        vld_q     <= 1'b1;
                        val_q     <= smp;
                        cnt_q[gi] <= CNT_W'(1);
                    end
                end
            end
        end
    endgenerate

    // Gather the count of the matching entry (zero when none matches).
    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) hit_cnt = hit_cnt | cnt_q[i];
        end
    end

    assign any_hit = |hit;
    assign new_cnt = any_hit ? (hit_cnt + 1'b1) : CNT_W'(1);

    // Advance the insert pointer whenever a new distinct value is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clr) begin
            fill_q <= '0;
        end else if (upd && !any_hit && (fill_q < FILL_W'(DEPTH))) begin
            fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/mvf_winner.sv
// Tracks the leading value and its count for the current read.
// The leader changes only when a count strictly exceeds the current maximum,
// so among equal counts the value that got there first stays in front.
module mvf_winner #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [DATA_W-1:0] smp,
    input  logic [CNT_W-1:0]  new_cnt,
    output logic [CNT_W-1:0]  max_nx,
    output logic [DATA_W-1:0] win_nx
);
    logic [CNT_W-1:0]  max_q;
    logic [DATA_W-1:0] win_q;
    logic              take;

    // Decide whether this sample's entry takes the lead.
    assign take   = upd && (new_cnt > max_q);
    assign max_nx = take ? new_cnt : max_q;
    assign win_nx = take ? smp     : win_q;

    // Register the leader for the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
            win_q <= '0;
        end else if (clr) begin
            max_q <= '0;
            win_q <= '0;
        end else begin
            max_q <= max_nx;
            win_q <= win_nx;
        end
    end
endmodule

// File: rtl/mvf_sequencer.sv
// Request handshake, sample run control and result register.
// Assumes the target returns smp_data in the same cycle smp_en is high.
// A run ends on the sample that lifts the maximum above NUM_SAMPLES/2,
// or on the NUM_SAMPLES-th sample.
module mvf_sequencer #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_SAMPLES = 100,
    parameter int CNT_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  max_nx,
    input  logic [DATA_W-1:0] win_nx,
    output logic              req_ready,
    output logic              clr,
    output logic              upd,
    output logic [ADDR_W-1:0] smp_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data
);
    import mvf_pkg::*;

    localparam int MAJ = NUM_SAMPLES / 2;

    mvf_state_t        state_q;
    logic [CNT_W-1:0]  taken_q;
    logic [CNT_W-1:0]  taken_nx;
    logic              finish;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign upd       = (state_q == ST_SAMPLE);
    assign accept    = req_ready && req_valid;
    assign clr       = accept;
    assign taken_nx  = taken_q + 1'b1;
    assign finish    = upd && ((max_nx > CNT_W'(MAJ)) ||
                               (taken_nx == CNT_W'(NUM_SAMPLES)));

    // Move between idle and sampling; count samples in the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            taken_q  <= '0;
            smp_addr <= '0;
        end else if (accept) begin
            state_q  <= ST_SAMPLE;
            taken_q  <= '0;
            smp_addr <= req_addr;
        end else if (finish) begin
            state_q  <= ST_IDLE;
            taken_q  <= taken_nx;
        end else if (upd) begin
            taken_q  <= taken_nx;
        end
    end

    // Pulse done and load the result word when a run ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_done <= finish;
            if (finish) rsp_data <= win_nx;
        end
    end
endmodule

// File: rtl/mvf_read_filter.sv
// Majority-vote read filter: samples one register up to NUM_SAMPLES times
// and returns the most frequent value, stopping once a strict majority exists.
// Assumes a single-cycle combinational target behind smp_addr/smp_data.
module mvf_read_filter #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_SAMPLES = 100,
    parameter int TABLE_DEPTH = NUM_SAMPLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              smp_en,
    output logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);

    logic              clr;
    logic              upd;
    logic [CNT_W-1:0]  new_cnt;
    logic [CNT_W-1:0]  max_nx;
    logic [DATA_W-1:0] win_nx;

    assign smp_en = upd;

    mvf_tally_table #(
        .DATA_W (DATA_W),
        .DEPTH  (TABLE_DEPTH),
        .CNT_W  (CNT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .upd     (upd),
        .smp     (smp_data),
        .new_cnt (new_cnt)
    );

    mvf_winner #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_winner (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .upd     (upd),
        .smp     (smp_data),
        .new_cnt (new_cnt),
        .max_nx  (max_nx),
        .win_nx  (win_nx)
    );

    mvf_sequencer #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .NUM_SAMPLES (NUM_SAMPLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .max_nx    (max_nx),
        .win_nx    (win_nx),
        .req_ready (req_ready),
        .clr       (clr),
        .upd       (upd),
        .smp_addr  (smp_addr),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/mvf_read_filter_chk.sv
// Protocol checker for mvf_read_filter, bound to every instance.
module mvf_read_filter_chk #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_SAMPLES = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              smp_en,
    input logic [ADDR_W-1:0] smp_addr,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data
);
    localparam int RUN_W = $clog2(NUM_SAMPLES + 1);

    logic [RUN_W-1:0] run_q;

    // Count consecutive sampling cycles of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (smp_en) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);                                   // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_done || $stable(rsp_data)));                 // R8
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);                                   // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> !req_ready);                                    // R2
    AST_START_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> smp_en);                      // R3
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && $past(smp_en)) |-> $stable(smp_addr));          // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> (run_q < RUN_W'(NUM_SAMPLES)));                 // R4
endmodule

bind mvf_read_filter mvf_read_filter_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_SAMPLES (NUM_SAMPLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .smp_en    (smp_en),
    .smp_addr  (smp_addr),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data)
);

// File: tb/tb_mvf_read_filter.sv
// Bench: reference tally in queues, compared with the design every cycle.
module tb_mvf_read_filter;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NS = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          smp_en;
    logic [AW-1:0] smp_addr;
    logic [DW-1:0] smp_data = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_data;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [DW-1:0] pat [NS];

    always #2.5 clk = ~clk;

    mvf_read_filter #(.DATA_W(DW), .ADDR_W(AW), .NUM_SAMPLES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .smp_en(smp_en), .smp_addr(smp_addr),
        .smp_data(smp_data), .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference: tally pat in order, return sample count and winning value.
    task automatic model(output int n, output logic [DW-1:0] v);
        logic [DW-1:0] vals[$];
        int cnts[$];
        int mx = 0;
        n = NS;
        v = '0;
        for (int k = 0; k < NS; k++) begin
            int j = -1;
            int c;
            foreach (vals[i]) if (vals[i] == pat[k]) j = i;
            if (j < 0) begin
                vals.push_back(pat[k]);
                cnts.push_back(1);
                c = 1;
            end else begin
                cnts[j] = cnts[j] + 1;
                c = cnts[j];
            end
            if (c > mx) begin
                mx = c;
                v = pat[k];
            end
            if (mx > NS / 2) begin
                n = k + 1;
                break;
            end
        end
    endtask

    // One filtered read, checked every cycle; poke_busy raises req_valid mid-run.
    task automatic do_read(input logic [AW-1:0] addr, input bit poke_busy,
                           input string tag, input logic [DW-1:0] exp_known);
        int n;
        logic [DW-1:0] v;
        model(n, v);
        chk(v == exp_known, {tag, " model"}, v, exp_known);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(smp_en == 1'b1 && req_ready == 1'b0, "R2 busy after accept", smp_en, 1);
        for (int k = 0; k < NS; k++) begin
            smp_data = pat[k];
            if (poke_busy && k == 5)  begin req_valid = 1'b1; req_addr = ~addr; end
            if (poke_busy && k == 6)  req_valid = 1'b0;
            chk(smp_addr == addr, "R3 sample address", smp_addr, addr);
            @(posedge clk);
            @(negedge clk);
            chk(rsp_done == (k + 1 == n), {tag, " R8 done timing"}, rsp_done, (k + 1 == n));
            chk(smp_en == (k + 1 < n), "R3 smp_en span", smp_en, (k + 1 < n));
            if (k + 1 == n) begin
                chk(rsp_data == v, {tag, " result"}, rsp_data, v);
                break;
            end
        end
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk(rsp_done == 1'b0 && rsp_data == v, "R8 result held", rsp_data, v);
            chk(req_ready == 1'b1 && smp_en == 1'b0, "R2 idle after read", req_ready, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && smp_en == 1'b0 && rsp_done == 1'b0 && rsp_data == '0,
            "R1 reset state", {req_ready, smp_en, rsp_done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_data == '0, "R1 idle after reset", rsp_data, 0);

        // R7: one constant value stops the run at sample 51
        for (int k = 0; k < NS; k++) pat[k] = 32'hCAFE_0001;
        do_read(8'h12, 1'b0, "R7 constant", 32'hCAFE_0001);

        // R4 R5: no majority, three values interleaved (40/35/25) -> 100 samples
        for (int k = 0; k < NS; k++)
            pat[k] = (k % 20 < 8) ? 32'hA : ((k % 20 < 15) ? 32'hB : 32'hC);
        do_read(8'h20, 1'b0, "R5 plurality", 32'hA);

        // R6: exact tie 50/50, B always first to each count
        for (int k = 0; k < NS; k++) pat[k] = (k % 2 == 0) ? 32'hBBBB : 32'hAAAA;
        do_read(8'h31, 1'b0, "R6 tie", 32'hBBBB);

        // R6: all distinct, first sample wins with count 1
        for (int k = 0; k < NS; k++) pat[k] = 32'h1000 + k;
        do_read(8'h44, 1'b0, "R6 all distinct", 32'h1000);

        // R7: 24 distinct then a run of D reaches 51 at sample 75
        for (int k = 0; k < NS; k++) pat[k] = (k < 24) ? (32'h500 + k) : 32'hD;
        do_read(8'h55, 1'b0, "R7 late majority", 32'hD);

        // R7 R4: majority reached only on the very last sample
        for (int k = 0; k < NS; k++) pat[k] = (k < 49) ? 32'hE1 : 32'hE2;
        do_read(8'h56, 1'b0, "R7 last sample", 32'hE2);

        // R2: a request raised mid-run is ignored
        for (int k = 0; k < NS; k++) pat[k] = (k % 3 == 0) ? 32'h77 : (32'h900 + k);
        do_read(8'h66, 1'b1, "R2 busy poke", 32'h77);

        // R9: earlier read leaves A with 45; next read must not reuse it
        for (int k = 0; k < NS; k++) pat[k] = (k < 45) ? 32'hA : 32'hF;
        do_read(8'h70, 1'b0, "R9 first", 32'hF);
        for (int k = 0; k < NS; k++)
            pat[k] = (k < 40) ? 32'hC : ((k < 70) ? 32'hA : (32'h2000 + k));
        do_read(8'h71, 1'b0, "R9 second", 32'hC);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule